// File: doc/BRIEF.md
# Self-Purging Triple-Redundant Output Selector

This block sits after three redundant copies of a controller. On every valid strobe it samples the three 32-bit results and compares them bit for bit. It raises a per-channel disagreement flag for any channel that stands apart from the other two. From the pattern of disagreements and its own sticky purge record, it decides which channel drives the single registered output. It also decides when the redundancy is used up and a system failure must be reported.

Two degradation policies are selectable by a mode input, which is consulted only at the first fault. In the purging policy the faulty channel is dropped and the two survivors must agree from then on. Any later disagreement between them is a failure. In the simplex policy the first fault drops the faulty channel together with one healthy partner, leaving a single channel. That channel is then checked against an externally supplied reference value. While no fault has been seen, both policies forward channel 0, so a healthy system looks exactly like one controller.

Top module: `tmr_purge_sel`

## Requirements
- R1: On each valid strobe, bit i of `err_o` (bit i = channel i) is set exactly when channel i differs from both other channels in that sample; the flags hold their value between strobes.
- R2: While no channel is purged and no failure is declared, a valid sample loads `out_o` with channel 0 in either mode (`mode_i` = 0 purging, 1 simplex).
- R3: In purging mode (`mode_i` = 0), the first single-channel disagreement sets that channel's bit in `purged_o` and loads `out_o` with the lowest-numbered surviving channel, in the same update.
- R4: In purging mode with one channel purged, a valid sample on which the two survivors agree loads `out_o` with the lower-numbered survivor; if they differ, `fail_o` is set.
- R5: In simplex mode (`mode_i` = 1), a first fault on channel 0 sets `purged_o` to 3'b101 and loads `out_o` from channel 1; a first fault on channel 1 or channel 2 sets `purged_o` to 3'b110 and loads `out_o` from channel 0.
- R6: In simplex operation, a valid sample on which the remaining channel differs from `ref_i` sets `fail_o`; if it matches, `out_o` is loaded from that channel.
- R7: If all three channels differ pairwise while none is purged, `fail_o` is set on that sample in either mode.
- R8: Purge bits and `fail_o` stay set until reset; once failed, `out_o` and `purged_o` no longer change.
- R9: Nothing but `err_o`, `out_o`, `purged_o` and `fail_o` changes on a valid strobe, and nothing changes without one; `mode_i` has no effect once a channel has been purged.
- R10: After reset `out_o`, `err_o`, `purged_o` and `fail_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Sample strobe for the three channels |
| mode_i | input | 1 | Degradation policy: 0 purging, 1 simplex |
| ch0_i | input | 32 | Channel 0 result |
| ch1_i | input | 32 | Channel 1 result |
| ch2_i | input | 32 | Channel 2 result |
| ref_i | input | 32 | Reference value checked in simplex operation |
| out_o | output | 32 | Selected output |
| err_o | output | 3 | Per-channel disagreement flags |
| purged_o | output | 3 | Sticky per-channel purge bits |
| fail_o | output | 1 | Sticky system failure flag |

## Verification
The bench first targets the switch away from channel 0. A design that picked the wrong survivor would output a stale or faulty value on the very update that purges channel 0. In simplex mode it would purge the wrong healthy partner, leaving channel 2 in place where channel 1 belongs. The second fault in purging mode and a reference mismatch in simplex mode must both end in failure with a frozen output; a design lacking stickiness would start forwarding again. A pairwise three-way disagreement, idle cycles with changing inputs, and a mode flip after degradation round out the cases. A design that treated any of these as an ordinary sample would leak values onto the output or purge extra channels.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NCH   = 3;
    localparam int SEL_W = 2;

    localparam logic MODE_PURGE   = 1'b0;
    localparam logic MODE_SIMPLEX = 1'b1;

    typedef enum logic [1:0] {
        ST_FULL    = 2'd0,
        ST_DUPLEX  = 2'd1,
        ST_SIMPLEX = 2'd2,
        ST_FAIL    = 2'd3
    } stage_e;

endpackage

// File: rtl/tmr_cmp.sv
// Exact-match comparison of all channel pairs and per-channel outlier flags.
module tmr_cmp
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [NCH-1:0][DW-1:0] ch_i,
    output logic [NCH-1:0]         eq_o,   // eq_o[g]: channel g equals channel (g+1)%NCH
    output logic [NCH-1:0]         odd_o   // odd_o[g]: channel g differs from both others
);

    for (genvar g = 0; g < NCH; g++) begin : g_pair
        localparam int NXT = (g + 1) % NCH;
        localparam int PRV = (g + 2) % NCH;
        assign eq_o[g]  = (ch_i[g] == ch_i[NXT]);
        assign odd_o[g] = (ch_i[g] != ch_i[NXT]) && (ch_i[g] != ch_i[PRV]);
    end

endmodule

// File: rtl/tmr_mux.sv
// Channel selector indexed by a small select code.
module tmr_mux
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [NCH-1:0][DW-1:0] ch_i,
    input  logic [SEL_W-1:0]       sel_i,
    output logic [DW-1:0]          val_o
);

    always_comb begin
        val_o = ch_i[0];
        for (int k = 0; k < NCH; k++) begin
            if (sel_i == SEL_W'(k)) begin
                val_o = ch_i[k];
            end
        end
    end

endmodule

// File: rtl/tmr_ctl.sv
// Degradation policy: decides the next stage, purge set and output channel.
module tmr_ctl
    import tmr_pkg::*;
(
    input  logic             valid_i,
    input  logic             mode_i,
    input  stage_e           stage_q_i,
    input  logic [NCH-1:0]   purged_q_i,
    input  logic [SEL_W-1:0] sel_q_i,
    input  logic [NCH-1:0]   eq_i,
    input  logic [NCH-1:0]   odd_i,
    input  logic             ref_ok_i,
    output stage_e           stage_d_o,
    output logic [NCH-1:0]   purged_d_o,
    output logic [SEL_W-1:0] sel_d_o,
    output logic             load_o
);

    logic all_diff;
    logic survivors_agree;
    logic [SEL_W-1:0] bad_idx;

    assign all_diff = ~|eq_i;

    always_comb begin
        bad_idx = '0;
        for (int c = 0; c < NCH; c++) begin
            if (odd_i[c]) begin
                bad_idx = SEL_W'(c);
            end
        end
    end

    always_comb begin
        survivors_agree = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (purged_q_i[c]) begin
                survivors_agree = eq_i[(c + 1) % NCH];
            end
        end
    end

    always_comb begin
        stage_d_o  = stage_q_i;
        purged_d_o = purged_q_i;
        sel_d_o    = sel_q_i;
        load_o     = 1'b0;
        if (valid_i) begin
            unique case (stage_q_i)
                ST_FULL: begin
                    if (all_diff) begin
                        stage_d_o = ST_FAIL;
                    end else if (|odd_i) begin
                        load_o = 1'b1;
                        if (mode_i == MODE_PURGE) begin
                            stage_d_o  = ST_DUPLEX;
                            purged_d_o = odd_i;
                            sel_d_o    = (bad_idx == '0) ? SEL_W'(1) : SEL_W'(0);
                        end else begin
                            stage_d_o = ST_SIMPLEX;
                            if (bad_idx == '0) begin
                                purged_d_o = 3'b101;
                                sel_d_o    = SEL_W'(1);
                            end else begin
                                purged_d_o = 3'b110;
                                sel_d_o    = SEL_W'(0);
                            end
                        end
                    end else begin
                        load_o  = 1'b1;
                        sel_d_o = '0;
                    end
                end
                ST_DUPLEX: begin
                    if (survivors_agree) begin
                        load_o = 1'b1;
                    end else begin
                        stage_d_o = ST_FAIL;
                    end
                end
                ST_SIMPLEX: begin
                    if (ref_ok_i) begin
                        load_o = 1'b1;
                    end else begin
                        stage_d_o = ST_FAIL;
                    end
                end
                default: begin
                    stage_d_o = ST_FAIL;
                end
            endcase
        end
    end

endmodule

// File: rtl/tmr_purge_sel.sv
// Top level: registers the selector state in two-process style.
module tmr_purge_sel
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          valid_i,
    input  logic          mode_i,
    input  logic [DW-1:0] ch0_i,
    input  logic [DW-1:0] ch1_i,
    input  logic [DW-1:0] ch2_i,
    input  logic [DW-1:0] ref_i,
    output logic [DW-1:0] out_o,
    output logic [2:0]    err_o,
    output logic [2:0]    purged_o,
    output logic          fail_o
);

    typedef struct packed {
        logic [DW-1:0]    out;
        logic [NCH-1:0]   err;
        logic [NCH-1:0]   purged;
        logic [SEL_W-1:0] sel;
        stage_e           stage;
    } state_t;

    state_t st_d, st_q;

    logic [NCH-1:0][DW-1:0] chans;
    logic [NCH-1:0]         eq;
    logic [NCH-1:0]         odd;
    logic [DW-1:0]          cur_val;
    logic [DW-1:0]          new_val;
    logic                   ref_ok;
    stage_e                 stage_nx;
    logic [NCH-1:0]         purged_nx;
    logic [SEL_W-1:0]       sel_nx;
    logic                   load;

    assign chans = {ch2_i, ch1_i, ch0_i};

    tmr_cmp #(.DW(DW)) cmp_i (
        .ch_i  (chans),
        .eq_o  (eq),
        .odd_o (odd)
    );

    tmr_mux #(.DW(DW)) cur_mux_i (
        .ch_i  (chans),
        .sel_i (st_q.sel),
        .val_o (cur_val)
    );

    assign ref_ok = (cur_val == ref_i);

    tmr_ctl ctl_i (
        .valid_i    (valid_i),
        .mode_i     (mode_i),
        .stage_q_i  (st_q.stage),
        .purged_q_i (st_q.purged),
        .sel_q_i    (st_q.sel),
        .eq_i       (eq),
        .odd_i      (odd),
        .ref_ok_i   (ref_ok),
        .stage_d_o  (stage_nx),
        .purged_d_o (purged_nx),
        .sel_d_o    (sel_nx),
        .load_o     (load)
    );

    tmr_mux #(.DW(DW)) new_mux_i (
        .ch_i  (chans),
        .sel_i (sel_nx),
        .val_o (new_val)
    );

    always_comb begin
        st_d        = st_q;
        st_d.stage  = stage_nx;
        st_d.purged = purged_nx;
        st_d.sel    = sel_nx;
        if (valid_i) begin
            st_d.err = odd;
        end
        if (load) begin
            st_d.out = new_val;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{out: '0, err: '0, purged: '0, sel: '0, stage: ST_FULL};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o    = st_q.out;
    assign err_o    = st_q.err;
    assign purged_o = st_q.purged;
    assign fail_o   = (st_q.stage == ST_FAIL);

endmodule

// File: rtl/tmr_purge_sel_chk.sv
// Property checker attached to the selector.
module tmr_purge_sel_chk #(
    parameter int DW = 32
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          valid_i,
    input logic          mode_i,
    input logic [DW-1:0] ch0_i,
    input logic [DW-1:0] ch1_i,
    input logic [DW-1:0] ch2_i,
    input logic [DW-1:0] out_o,
    input logic [2:0]    err_o,
    input logic [2:0]    purged_o,
    input logic          fail_o
);

    AST_PURGE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((purged_o & $past(purged_o)) == $past(purged_o))); // R8

    AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_o |=> fail_o); // R8

    AST_FAIL_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_o |=> ($stable(out_o) && $stable(purged_o))); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> ($stable(out_o) && $stable(err_o) && $stable(purged_o) && $stable(fail_o))); // R9

    AST_FAULTFREE_CH0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && ch0_i == ch1_i && ch1_i == ch2_i && purged_o == 3'b000 && !fail_o)
        |=> (out_o == $past(ch0_i) && err_o == 3'b000)); // R2

    AST_FIRST_PURGE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && !mode_i && purged_o == 3'b000 && !fail_o)
        |=> ($countones(purged_o) <= 1)); // R3

    AST_PURGE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(purged_o) <= 2); // R5

endmodule

bind tmr_purge_sel tmr_purge_sel_chk #(.DW(DW)) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .mode_i   (mode_i),
    .ch0_i    (ch0_i),
    .ch1_i    (ch1_i),
    .ch2_i    (ch2_i),
    .out_o    (out_o),
    .err_o    (err_o),
    .purged_o (purged_o),
    .fail_o   (fail_o)
);

// File: tb/tmr_purge_sel_tb.sv
module tmr_purge_sel_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          valid_i = 1'b0;
    logic          mode_i = 1'b0;
    logic [DW-1:0] ch0_i = '0, ch1_i = '0, ch2_i = '0, ref_i = '0;
    logic [DW-1:0] out_o;
    logic [2:0]    err_o, purged_o;
    logic          fail_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int            m_stage;   // 0 full, 1 two left, 2 one left, 3 failed
    int            m_keep;    // survivor used in one-left operation
    logic [DW-1:0] m_out;
    logic [2:0]    m_err, m_purged;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_purge_sel #(.DW(DW)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
        .ch0_i(ch0_i), .ch1_i(ch1_i), .ch2_i(ch2_i), .ref_i(ref_i),
        .out_o(out_o), .err_o(err_o), .purged_o(purged_o), .fail_o(fail_o)
    );

    task automatic model_reset();
        m_stage = 0; m_keep = 0; m_out = '0; m_err = '0; m_purged = '0;
    endtask

    task automatic model_step(input logic v, input logic md,
                              input logic [DW-1:0] a, b, c, r);
        logic [DW-1:0] x[3];
        int bad;
        int s[$];
        if (!v) return;
        x[0] = a; x[1] = b; x[2] = c;
        bad = -1;
        for (int i = 0; i < 3; i++) begin
            m_err[i] = (x[i] != x[(i+1)%3]) && (x[i] != x[(i+2)%3]);
            if (m_err[i]) bad = i;
        end
        if (m_stage == 0) begin
            if (a != b && b != c && a != c) m_stage = 3;
            else if (bad < 0) m_out = a;
            else if (md == 1'b0) begin
                m_purged[bad] = 1'b1;
                m_stage = 1;
                m_out = (bad == 0) ? b : a;
            end else begin
                m_keep = (bad == 0) ? 1 : 0;
                m_purged = 3'b111;
                m_purged[m_keep] = 1'b0;
                m_stage = 2;
                m_out = x[m_keep];
            end
        end else if (m_stage == 1) begin
            for (int i = 0; i < 3; i++) if (!m_purged[i]) s.push_back(i);
            if (x[s[0]] == x[s[1]]) m_out = x[s[0]];
            else m_stage = 3;
        end else if (m_stage == 2) begin
            if (x[m_keep] == r) m_out = x[m_keep];
            else m_stage = 3;
        end
    endtask

    task automatic compare(input string tag);
        logic m_fail;
        m_fail = (m_stage == 3);
        checks++;
        if (out_o !== m_out || err_o !== m_err || purged_o !== m_purged || fail_o !== m_fail) begin
            errors++;
            $display("FAIL %s: out=%h err=%b purged=%b fail=%b expected out=%h err=%b purged=%b fail=%b",
                     tag, out_o, err_o, purged_o, fail_o, m_out, m_err, m_purged, m_fail);
        end
    endtask

    task automatic step(input string tag, input logic v, input logic md,
                        input logic [DW-1:0] a, b, c, r);
        valid_i = v; mode_i = md; ch0_i = a; ch1_i = b; ch2_i = c; ref_i = r;
        @(posedge clk);
        model_step(v, md, a, b, c, r);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst_ni = 1'b0; valid_i = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_ni = 1'b1;
        compare("R10 reset state");
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        do_reset();

        // R2 fault-free in both modes, R9 idle cycles hold
        step("R2 equal purge mode", 1, 0, 32'h11, 32'h11, 32'h11, 0);
        step("R2 equal simplex mode", 1, 1, 32'hDEADBEEF, 32'hDEADBEEF, 32'hDEADBEEF, 0);
        step("R9 idle with noise", 0, 0, 32'h1, 32'h2, 32'h3, 0);
        step("R9 idle outlier", 0, 1, 32'h5, 32'h6, 32'h6, 0);

        // R3/R1 purging mode, fault on channel 1, then R4 survivors
        step("R3 R1 ch1 outlier", 1, 0, 32'hA0, 32'hFF, 32'hA0, 0);
        step("R4 survivors agree", 1, 1, 32'hB0, 32'h00, 32'hB0, 32'h1);
        step("R9 mode ignored after purge", 1, 1, 32'hC0, 32'hC0, 32'hC0, 32'h9);
        step("R4 survivors differ", 1, 0, 32'hD0, 32'hD0, 32'hD1, 0);
        step("R8 failed holds", 1, 0, 32'hE0, 32'hE0, 32'hE0, 0);
        step("R8 failed holds outlier", 1, 0, 32'hE0, 32'h1, 32'hE0, 0);

        // R3 purging mode, fault on channel 0 switches output to channel 1
        do_reset();
        step("R3 ch0 outlier", 1, 0, 32'h7, 32'h42, 32'h42, 0);
        step("R4 survivors 1 and 2", 1, 0, 32'h0, 32'h43, 32'h43, 0);

        // R5/R6 simplex mode, fault on channel 0
        do_reset();
        step("R2 simplex healthy", 1, 1, 32'h10, 32'h10, 32'h10, 0);
        step("R5 simplex ch0 outlier", 1, 1, 32'h99, 32'h20, 32'h20, 32'h0);
        step("R6 simplex ref match", 1, 1, 32'h0, 32'h21, 32'h5, 32'h21);
        step("R6 simplex ref mismatch", 1, 1, 32'h0, 32'h22, 32'h22, 32'h23);
        step("R8 simplex failed holds", 1, 1, 32'h30, 32'h30, 32'h30, 32'h30);

        // R5 simplex mode, fault on channel 2 and on channel 1
        do_reset();
        step("R5 simplex ch2 outlier", 1, 1, 32'h55, 32'h55, 32'h66, 0);
        step("R6 simplex ch0 ref match", 1, 0, 32'h57, 32'h1, 32'h2, 32'h57);
        do_reset();
        step("R5 simplex ch1 outlier", 1, 1, 32'h77, 32'h78, 32'h77, 0);
        step("R6 simplex ch0 ref mismatch", 1, 1, 32'h79, 32'h79, 32'h79, 32'h7A);

        // R7 three-way disagreement in both modes
        do_reset();
        step("R2 before R7", 1, 0, 32'h3, 32'h3, 32'h3, 0);
        step("R7 all differ purge mode", 1, 0, 32'h1, 32'h2, 32'h4, 0);
        do_reset();
        step("R7 all differ simplex mode", 1, 1, 32'h8, 32'h9, 32'hA, 32'h8);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule